// File: doc/BRIEF.md
# Eight-Channel Shared-Period PWM Timer

This block is a word-addressed timer that drives up to eight pulse-width-modulated outputs from one free-running up-counter. All channels share the counter, its start value and its modulo, so they all have the same period. Each channel compares the shared count against its own compare value to set its duty cycle. A per-channel polarity bit inverts the output, and a per-channel mask bit forces the output to its inactive level. While the counter is stopped, each channel drives a programmable initial level.

Software writes the control word to pick a counting source and a power-of-two prescale. The sources are every clock, a fixed-rate tick input or an external tick input. Modulo and compare writes are double-buffered. While the counter runs, new values take effect only at the next reload, so no period is cut short. The counter is governed by a two-state machine. STOPPED holds the count at the start value and loads all buffered values at once. RUNNING advances the count on each prescaled tick. The transition STOPPED to RUNNING happens on the clock after a nonzero source code is written. The transition RUNNING to STOPPED happens on the clock after the source code returns to zero.

Top module: `shared_period_pwm`

## Requirements
- R1: After reset all outputs are low, the control word at 0x00 reads 0, the mask at 0x60 reads 0xFF and the modulo at 0x08 reads 0xFFFF.
- R2: Control bits 2:0 hold PS and bits 4:3 the source code (1 every clock, 2 `fix_tick`, 3 `ext_tick`). Each count value lasts 2^PS source ticks.
- R3: When running, the count at 0x04 steps from the start value at 0x4C up to the modulo, then reloads the start value. A period is therefore MOD - START + 1 prescaled ticks.
- R4: Source code 0 puts the block in STOPPED, where the count stays at the start value.
- R5: A channel whose control register (0x0C + 8n) has bits 5 and 3 set (value 0x28) is high while the count is below its compare value (0x10 + 8n) and low otherwise. A compare value of 0 gives 0% duty; any value above the modulo gives 100%.
- R6: When running, a channel without both of those bits set has a low raw level.
- R7: Bit n of the polarity register at 0x70 inverts channel n.
- R8: Bit n of the mask register at 0x60 forces channel n to its inactive level, which equals its polarity bit.
- R9: In STOPPED, each unmasked channel's raw level is bit n of the initial-level register at 0x5C.
- R10: Modulo and compare writes take effect at the next reload while running, and immediately while stopped.
- R11: Registers read back their stored fields (channel control keeps bits 5:2). Offsets that are not implemented read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fix_tick | input | 1 | Fixed-rate count enable (source 2) |
| ext_tick | input | 1 | External count enable (source 3) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 8 | Channel outputs |

## Verification
Random trials pick the source, prescale, start value, modulo, compare values, modes, polarity, mask and initial levels. Each trial first compares the outputs while stopped against the initial levels, which tells the initial-level path apart from the mask path. It then counts high cycles per channel over exactly two periods. That count depends only on period and duty, so it separates errors in prescale, source selection, reload and compare, whatever the phase. Directed cases cover compare values of 0, of the start value and of MOD+1, and partially set mode bits. A mid-period modulo shrink shows that the counter still runs past the new limit until the reload. Counter reads after a stop show that the count is held.

// File: rtl/spp_pkg.sv
package spp_pkg;
    localparam int ADDR_W = 8;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } cnt_state_e;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_MOD   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_START = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_INIT  = 8'h5C;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_POL   = 8'h70;

    localparam logic [1:0] SRC_OFF = 2'd0;
    localparam logic [1:0] SRC_CLK = 2'd1;
    localparam logic [1:0] SRC_FIX = 2'd2;
    localparam logic [1:0] SRC_EXT = 2'd3;

    function automatic logic [ADDR_W-1:0] ch_mode_off(input int n);
        return ADDR_W'(12 + 8 * n);
    endfunction

    function automatic logic [ADDR_W-1:0] ch_cmp_off(input int n);
        return ADDR_W'(16 + 8 * n);
    endfunction
endpackage

// File: rtl/spp_prescale.sv
module spp_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [1:0]      src_sel,
    input  logic            fix_tick,
    input  logic            ext_tick,
    input  logic [PS_W-1:0] ps,
    output logic            adv
);
    import spp_pkg::*;

    localparam int PRE_W = (1 << PS_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;
    logic             src_tick;

    always_comb begin
        unique case (src_sel)
            SRC_CLK: src_tick = 1'b1;
            SRC_FIX: src_tick = fix_tick;
            SRC_EXT: src_tick = ext_tick;
            default: src_tick = 1'b0;
        endcase
    end

    assign lim = PRE_W'((1 << ps) - 1);
    assign adv = !clr && src_tick && (pre_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (src_tick) begin
            if (pre_q >= lim) pre_q <= '0;
            else              pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/spp_counter.sv
module spp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic             adv,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] mod_wr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] mod_act,
    output logic             running,
    output logic             reload,
    output logic             load_en
);
    import spp_pkg::*;

    cnt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (run_req)  state_d = ST_RUNNING;
            ST_RUNNING: if (!run_req) state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_RUNNING);
        reload  = running && adv && (cnt >= mod_act);
        load_en = !running || reload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            mod_act <= '1;
        end else begin
            if (load_en) mod_act <= mod_wr;
            if (!running)    cnt <= start_val;
            else if (reload) cnt <= start_val;
            else if (adv)    cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spp_channel.sv
module spp_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_wr,
    input  logic             mode_en,
    input  logic             init_bit,
    input  logic             pol_bit,
    input  logic             mask_bit,
    output logic             out
);
    logic [CNT_W-1:0] cmp_act;
    logic             raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cmp_act <= '0;
        else if (load_en) cmp_act <= cmp_wr;
    end

    always_comb begin
        if (running) raw = mode_en && (cnt < cmp_act);
        else         raw = init_bit;
        out = mask_bit ? pol_bit : (raw ^ pol_bit);
    end
endmodule

// File: rtl/shared_period_pwm.sv
module shared_period_pwm #(
    parameter int NCH   = 8,
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fix_tick,
    input  logic        ext_tick,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [7:0]  pwm_out
);
    import spp_pkg::*;

    localparam int PS_W = 3;

    logic [4:0]       ctrl_q;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] start_q;
    logic [NCH-1:0]   init_q;
    logic [NCH-1:0]   mask_q;
    logic [NCH-1:0]   pol_q;
    logic [3:0]       mode_q [NCH];
    logic [CNT_W-1:0] cmp_q  [NCH];

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mod_act;
    logic             running;
    logic             reload;
    logic             load_en;
    logic             adv;
    logic [NCH-1:0]   ch_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mod_q   <= '1;
            start_q <= '0;
            init_q  <= '0;
            mask_q  <= '1;
            pol_q   <= '0;
            for (int i = 0; i < NCH; i++) begin
                mode_q[i] <= '0;
                cmp_q[i]  <= '0;
            end
        end else if (bus_wr) begin
            unique case (bus_addr)
                OFF_CTRL:  ctrl_q  <= bus_wdata[4:0];
                OFF_MOD:   mod_q   <= bus_wdata[CNT_W-1:0];
                OFF_START: start_q <= bus_wdata[CNT_W-1:0];
                OFF_INIT:  init_q  <= bus_wdata[NCH-1:0];
                OFF_MASK:  mask_q  <= bus_wdata[NCH-1:0];
                OFF_POL:   pol_q   <= bus_wdata[NCH-1:0];
                default: ;
            endcase
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == ch_mode_off(i)) mode_q[i] <= bus_wdata[5:2];
                if (bus_addr == ch_cmp_off(i))  cmp_q[i]  <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CTRL:  bus_rdata = 32'(ctrl_q);
            OFF_COUNT: bus_rdata = 32'(cnt_q);
            OFF_MOD:   bus_rdata = 32'(mod_q);
            OFF_START: bus_rdata = 32'(start_q);
            OFF_INIT:  bus_rdata = 32'(init_q);
            OFF_MASK:  bus_rdata = 32'(mask_q);
            OFF_POL:   bus_rdata = 32'(pol_q);
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ch_mode_off(i)) bus_rdata = 32'({mode_q[i], 2'b00});
            if (bus_addr == ch_cmp_off(i))  bus_rdata = 32'(cmp_q[i]);
        end
    end

    spp_prescale #(.PS_W(PS_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!running),
        .src_sel  (ctrl_q[4:3]),
        .fix_tick (fix_tick),
        .ext_tick (ext_tick),
        .ps       (ctrl_q[2:0]),
        .adv      (adv)
    );

    spp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_req   (ctrl_q[4:3] != SRC_OFF),
        .adv       (adv),
        .start_val (start_q),
        .mod_wr    (mod_q),
        .cnt       (cnt_q),
        .mod_act   (mod_act),
        .running   (running),
        .reload    (reload),
        .load_en   (load_en)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        spp_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (load_en),
            .running  (running),
            .cnt      (cnt_q),
            .cmp_wr   (cmp_q[g]),
            .mode_en  (mode_q[g][3] && mode_q[g][1]),
            .init_bit (init_q[g]),
            .pol_bit  (pol_q[g]),
            .mask_bit (mask_q[g]),
            .out      (ch_out[g])
        );
    end

    always_comb begin
        pwm_out = '0;
        pwm_out[NCH-1:0] = ch_out;
    end
endmodule

// File: rtl/spp_chk.sv
module spp_chk #(
    parameter int NCH   = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             adv,
    input logic             reload,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] start_val,
    input logic [CNT_W-1:0] mod_act,
    input logic [NCH-1:0]   pol,
    input logic [NCH-1:0]   mask,
    input logic [7:0]       pwm_out
);
    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> cnt == $past(start_val));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && adv && !reload) |=> cnt == $past(cnt) + 1'b1);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !adv) |=> $stable(cnt));

    // R4
    stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> cnt == $past(start_val));

    // R10
    mod_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !reload) |=> $stable(mod_act));

    // R8
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out[NCH-1:0] ^ pol) & mask) == '0);
endmodule

bind shared_period_pwm spp_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .running   (running),
    .adv       (adv),
    .reload    (reload),
    .cnt       (cnt_q),
    .start_val (start_q),
    .mod_act   (mod_act),
    .pol       (pol_q),
    .mask      (mask_q),
    .pwm_out   (pwm_out)
);

// File: tb/sim_shared_period_pwm.sv
module sim_shared_period_pwm;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        fix_tick = 0;
    logic        ext_tick = 0;
    logic        bus_wr = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [7:0]  pwm_out;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int fix_ph = 0;
    int ext_ph = 0;

    shared_period_pwm u0 (
        .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick), .ext_tick(ext_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        fix_ph <= (fix_ph == 2) ? 0 : fix_ph + 1;
        ext_ph <= (ext_ph == 1) ? 0 : ext_ph + 1;
        fix_tick <= (fix_ph == 2);
        ext_tick <= (ext_ph == 1);
    end

    task automatic chk(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic int high_ticks(int md, int st, int cv);
        int lim = (cv < md + 1) ? cv : md + 1;
        return (lim > st) ? lim - st : 0;
    endfunction

    function automatic int src_div(int src);
        return (src == 2) ? 3 : (src == 3) ? 2 : 1;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, a0, b0;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", pwm_out, 0);
        rd(8'h00, d); chk("R1 ctrl", d, 0);
        rd(8'h60, d); chk("R1 mask", d, 255);
        rd(8'h08, d); chk("R1 mod", d, 65535);
        // R11 readback and unimplemented offsets
        wr(8'h24, 32'hFF); rd(8'h24, d); chk("R11 mode keeps 5:2", d, 32'h3C);
        wr(8'h50, 32'h1234); rd(8'h50, d); chk("R11 unimplemented", d, 0);
        rd(8'hFC, d); chk("R11 unimplemented high", d, 0);
        wr(8'h28, 32'h77); rd(8'h28, d); chk("R11 compare ch3", d, 32'h77);

        for (int t = 0; t < 10; t++) begin
            int md, st, src, ps, per, win;
            int cv[8]; int mode[8]; int hi[8];
            logic [7:0] pol, msk, ini, expo;
            md  = 3 + $urandom % 38;
            st  = $urandom % (md / 2 + 1);
            src = 1 + $urandom % 3;
            ps  = $urandom % 4;
            pol = 8'($urandom); msk = 8'($urandom); ini = 8'($urandom);
            for (int i = 0; i < 8; i++) begin
                cv[i] = $urandom % (md + 3);
                mode[i] = ($urandom % 4 != 0) ? 32'h28 : (($urandom % 2) ? 32'h20 : 32'h08);
            end
            if (t == 0) begin
                cv[0] = 0; cv[1] = md + 1; cv[2] = st;
                mode[0] = 32'h28; mode[1] = 32'h28; mode[2] = 32'h28;
                msk = 8'h00;
            end
            wr(8'h00, 0);
            wr(8'h08, 32'(md)); wr(8'h4C, 32'(st));
            for (int i = 0; i < 8; i++) begin
                wr(8'(12 + 8 * i), 32'(mode[i]));
                wr(8'(16 + 8 * i), 32'(cv[i]));
            end
            wr(8'h70, 32'(pol)); wr(8'h60, 32'(msk)); wr(8'h5C, 32'(ini));
            repeat (2) @(negedge clk);
            // R9 initial level while stopped, R8 mask, R7 polarity
            expo = (msk & pol) | (~msk & (ini ^ pol));
            chk("R9 stopped outputs", pwm_out, expo);
            per = (md - st + 1) * (1 << ps) * src_div(src);
            win = 2 * per;
            wr(8'h00, 32'((src << 3) | ps));
            repeat (per + 4) @(negedge clk);
            for (int i = 0; i < 8; i++) hi[i] = 0;
            for (int c = 0; c < win; c++) begin
                @(negedge clk);
                for (int i = 0; i < 8; i++) hi[i] += pwm_out[i];
            end
            for (int i = 0; i < 8; i++) begin
                int e;
                if (msk[i]) e = pol[i] ? win : 0;                                   // R8
                else if (mode[i] != 32'h28) e = pol[i] ? win : 0;                   // R6
                else begin
                    e = 2 * high_ticks(md, st, cv[i]) * (1 << ps) * src_div(src);   // R5 R2 R3
                    if (pol[i]) e = win - e;                                        // R7
                end
                chk("R5 R2 R3 R6 R7 R8 duty over two periods", hi[i], e);
            end
            rd(8'h04, d);
            chk("R3 count within range", (d >= st && d <= md) ? 1 : 0, 1);
        end

        // R10 modulo shrink mid-period waits for reload
        wr(8'h00, 0); wr(8'h4C, 0); wr(8'h08, 99); wr(8'h00, 32'h08);
        d = 0;
        for (int k = 0; k < 300; k++) begin
            rd(8'h04, d);
            if (d >= 5 && d <= 40) break;
        end
        wr(8'h08, 20);
        rd(8'h04, a0);
        repeat (29) @(negedge clk);
        rd(8'h04, b0);
        chk("R10 count passes new modulo before reload", b0, a0 + 30);
        repeat (150) @(negedge clk);
        rd(8'h04, d);
        chk("R10 new modulo after reload", (d <= 20) ? 1 : 0, 1);

        // R4 stopped holds start value
        wr(8'h4C, 6); wr(8'h00, 0);
        repeat (3) @(negedge clk);
        rd(8'h04, a0);
        repeat (10) @(negedge clk);
        rd(8'h04, b0);
        chk("R4 stopped count held", b0, a0);
        chk("R4 stopped count equals start", a0, 6);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule